// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into the bit-timing strobes that a serial transceiver needs. A fractional prescaler comes first. A 10-bit step is added to a 10-bit phase accumulator on every clock, and each carry out of that sum becomes a clock enable. The enable rate is therefore the clock rate times step/1024. A 13-bit down-counter with a reload value then divides the enable stream by reload+1. A bypass input skips the fractional stage, so the counter sees an enable on every clock.

The output of the counter feeds one of two strobes, chosen by a mode input. In asynchronous mode the counter's pulse is a 16x oversampling tick, so the fastest bit rate is clock/16. In synchronous mode the pulse is divided by four again and gives a 2x shift tick, so the fastest bit rate is clock/8. All three stages start from a known phase each time the run input rises. While the block is stopped, the counter follows the reload input, so a new divisor takes effect on the first cycle after restart.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, tick_os and tick_sync are both 0.
- R2: With bypass=0 and run held high from a stopped state, exactly floor(N*step/1024) enables are produced in the first N clocks. Each enable is a carry out of the 10-bit phase sum. step=0 yields no ticks.
- R3: With bypass=1, every clock with run high is an enable, whatever the value of step.
- R4: The counter emits one pulse per reload+1 enables. With bypass=1 and sync_mode=0, the first tick_os is seen on the (reload+1)-th clock after run rises. Later ticks follow every reload+1 clocks.
- R5: With sync_mode=0 only tick_os pulses. With sync_mode=1 tick_os stays 0, and tick_sync pulses once per four counter pulses, the first on the fourth.
- R6: One clock after run is sampled low, both ticks are 0 and stay 0 while run is low. The accumulator and the sync divider restart from zero.
- R7: A reload value changed while stopped governs the very first period after restart, not only later ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Generator enable; low holds all stages at their start phase |
| bypass | input | 1 | 1 = feed every clock to the reload counter |
| sync_mode | input | 1 | 0 = 16x oversampling tick, 1 = 2x synchronous tick |
| reload | input | 13 | Counter divisor minus one |
| step | input | 10 | Fractional increment per clock (rate = step/1024) |
| tick_os | output | 1 | Single-cycle oversampling strobe |
| tick_sync | output | 1 | Single-cycle synchronous shift strobe |

## Verification
Both strobes are registered. A counter pulse caused by the enable at a clock edge appears on the port right after that same edge. The bench samples on the falling edge, so sample number i after run rises reflects the enable of the i-th rising edge. The first tick_os with bypass is due on sample reload+1, and the first tick_sync on sample 4*(reload+1). Over a window of N samples, the tick count must equal the enable count from the step formula divided by the period. After run falls, the bench waits one rising edge before it requires both strobes to read zero.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RELOAD_W = 13,
  parameter int FRAC_W   = 10,
  parameter int SYNC_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                bypass,
  input  logic                sync_mode,
  input  logic [RELOAD_W-1:0] reload,
  input  logic [FRAC_W-1:0]   step,
  output logic                tick_os,
  output logic                tick_sync
);
  localparam int PRE_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SYNC_DIV - 1);

  logic [FRAC_W-1:0]   acc;
  logic [RELOAD_W-1:0] cnt;
  logic [PRE_W-1:0]    pre;
  logic [FRAC_W:0]     acc_sum;
  logic                en, at_zero, rl_pulse;

  assign acc_sum  = {1'b0, acc} + {1'b0, step};
  assign en       = run & (bypass | acc_sum[FRAC_W]);
  assign at_zero  = (cnt == '0);
  assign rl_pulse = en & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      pre       <= '0;
      tick_os   <= 1'b0;
      tick_sync <= 1'b0;
    end else if (!run) begin
      acc       <= '0;
      cnt       <= reload;
      pre       <= '0;
      tick_os   <= 1'b0;
      tick_sync <= 1'b0;
    end else begin
      acc <= acc_sum[FRAC_W-1:0];
      if (en) cnt <= at_zero ? reload : cnt - 1'b1;
      if (rl_pulse && sync_mode) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      tick_os   <= rl_pulse & ~sync_mode;
      tick_sync <= rl_pulse & sync_mode & (pre == PRE_LAST);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !tick_os && !tick_sync);

  p_bypass_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && bypass && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && bypass && cnt == '0 |=> cnt == $past(reload));

  p_mode_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_os && tick_sync));

  p_sync_no_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && sync_mode |=> !tick_os);

  p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_os && !tick_sync && acc == '0);

  p_stop_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(reload));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        bypass = 1'b0;
  logic        sync_mode = 1'b0;
  logic [12:0] reload = '0;
  logic [9:0]  step = '0;
  logic        tick_os, tick_sync;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run), .bypass(bypass), .sync_mode(sync_mode),
    .reload(reload), .step(step), .tick_os(tick_os), .tick_sync(tick_sync)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_enables(longint n, int stp, bit byp);
    return byp ? n : (n * stp) / 1024;
  endfunction

  function automatic longint exp_ticks(longint n, int stp, bit byp, int r, bit sm);
    longint per = sm ? 4 * (r + 1) : (r + 1);
    return exp_enables(n, stp, byp) / per;
  endfunction

  task automatic run_case(int r, int stp, bit byp, bit sm, int n);
    int main_cnt = 0, other_cnt = 0, first = 0;
    @(negedge clk);
    run = 1'b0; reload = 13'(r); step = 10'(stp); bypass = byp; sync_mode = sm;
    repeat (2) @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if ((sm ? tick_sync : tick_os) == 1'b1) begin
        main_cnt++;
        if (first == 0) first = i;
      end
      if ((sm ? tick_os : tick_sync) == 1'b1) other_cnt++;
    end
    check(byp ? "R3/R4 tick count" : "R2/R4 tick count", main_cnt,
          exp_ticks(n, stp, byp, r, sm));
    check("R5 idle strobe stays low", other_cnt, 0);
    if (byp && n >= 4 * (r + 1))
      check("R4/R5 first tick sample", first, sm ? 4 * (r + 1) : r + 1);
    run = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R6 stopped tick_os", tick_os, 0);
      check("R6 stopped tick_sync", tick_sync, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) begin
      @(negedge clk);
      check("R1 reset tick_os", tick_os, 0);
      check("R1 reset tick_sync", tick_sync, 0);
    end
    rst_n = 1'b1;

    run_case(0, 0, 1'b1, 1'b0, 64);
    run_case(5, 0, 1'b1, 1'b0, 120);
    run_case(2, 0, 1'b1, 1'b1, 200);
    run_case(0, 0, 1'b0, 1'b0, 500);
    run_case(0, 512, 1'b0, 1'b0, 1000);
    run_case(0, 1023, 1'b0, 1'b0, 2048);
    run_case(3, 1, 1'b0, 1'b1, 3000);
    run_case(1, 777, 1'b1, 1'b0, 300);

    // R7: reload changed while stopped sets the first period
    run_case(7, 0, 1'b1, 1'b0, 40);
    run_case(2, 0, 1'b1, 1'b0, 30);
    run_case(9, 0, 1'b1, 1'b1, 120);

    for (int k = 0; k < 30; k++) begin
      int r   = int'($urandom_range(0, 20));
      int stp = int'($urandom_range(0, 1023));
      bit byp = 1'($urandom_range(0, 1));
      bit sm  = 1'($urandom_range(0, 1));
      int n   = int'($urandom_range(200, 3000));
      run_case(r, stp, byp, sm, n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule